// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into a physical address by fetching two entries from page tables held in memory. The linear address is divided, from the top bit down, into a 10-bit directory index, a 10-bit table index and a 12-bit page offset. The walker first fetches the directory entry. That entry locates a second-level table. The walker then fetches the table entry, which supplies the physical frame. The result is the frame joined to the untouched offset, so every page is 4 KiB.

A requester presents an address on a valid/ready request port. The answer returns on a one-cycle response strobe carrying the physical address and a fault flag. The walker uses a single read port towards memory, with one read in flight at a time, and tolerates any read latency. Two control inputs select the address space: the directory base address and a paging switch. Both are captured when a request is accepted. When paging is off, the address is returned unchanged and memory is never read.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A request accepted while `paging_en` is 0 is answered in the next cycle with `rsp_paddr` equal to the request address and `rsp_fault` 0, and no memory read is issued.
- R3: A request accepted while `paging_en` is 1 raises `mem_req` in the next cycle with `mem_addr` = directory base + 4 × address bits [31:22].
- R4: When the directory entry has bit 0 set, the second read uses `mem_addr` = {directory entry bits [31:12], 12'h000} + 4 × address bits [21:12]. Entry bits [11:1] are ignored.
- R5: When the table entry has bit 0 set, the response carries `rsp_paddr` = {table entry bits [31:12], address bits [11:0]} and `rsp_fault` 0.
- R6: A directory entry with bit 0 clear ends the walk after one read, with `rsp_fault` 1 and `rsp_paddr` 0.
- R7: A table entry with bit 0 clear ends the walk after two reads, with `rsp_fault` 1 and `rsp_paddr` 0.
- R8: `req_ready` is 0 from acceptance until the response cycle ends. A request held during that time is ignored: no extra response or read results from it.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_rvalid` is seen. Only one read is in flight, and any number of wait cycles is tolerated.
- R10: `rsp_valid` is high for exactly one cycle per accepted request. The walker is ready again in the cycle after the response.
- R11: `paging_en` and `dir_base` are sampled at acceptance. Changing them during a walk does not alter that walk's reads or result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| paging_en | input | 1 | 1 = translate through tables, 0 = pass address through |
| dir_base | input | 32 | Byte address of the page directory |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Linear address to translate |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Page fault: an entry was not present |
| mem_req | output | 1 | Read request, held until data returns |
| mem_addr | output | 32 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data valid, ends the current read |
| mem_rdata | input | 32 | Entry read from memory |

## Verification
On every cycle, the assertions check the handshake shape of the block. They confirm that a read stays stable until its data arrives, that the walker never takes a request while a read is pending, and that the response strobe lasts one cycle. They also check that faults carry a zero address, and that bypass requests and the first directory fetch follow acceptance by exactly one cycle. Only the bench scenarios can show the data-dependent results: the second-level address built from the directory entry, the frame and offset joined into the final address, and the number of reads on each fault path. The same applies to ignoring a held request and to control changes made during a walk, since these depend on table contents prepared in the bench's memory model.

// File: rtl/ptw_pkg.sv
`timescale 1ns/1ps
package ptw_pkg;

    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_DIR  = 2'd1,
        WALK_TBL  = 2'd2,
        WALK_RESP = 2'd3
    } walk_state_e;

    localparam int unsigned ENTRY_BYTES = 4;

endpackage

// File: rtl/ptw_entry_addr.sv
`timescale 1ns/1ps
// Forms the byte address of one table entry: base + index * entry size.
module ptw_entry_addr #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned IDX_W       = 10,
    parameter int unsigned ENTRY_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int unsigned SHIFT = $clog2(ENTRY_BYTES);

    logic [ADDR_W-1:0] scaled;

    always_comb begin
        scaled = ADDR_W'(idx_i) << SHIFT;
        addr_o = base_i + scaled;
    end
endmodule

// File: rtl/ptw_entry_decode.sv
`timescale 1ns/1ps
// Splits a table entry into its present flag and its frame/table number.
module ptw_entry_decode #(
    parameter int unsigned ENTRY_W     = 32,
    parameter int unsigned FRAME_W     = 20,
    parameter int unsigned PRESENT_BIT = 0
) (
    input  logic [ENTRY_W-1:0] entry_i,
    output logic               present_o,
    output logic [FRAME_W-1:0] frame_o
);
    always_comb begin
        present_o = entry_i[PRESENT_BIT];
        frame_o   = entry_i[ENTRY_W-1 -: FRAME_W];
    end
endmodule

// File: rtl/ptw_walker.sv
`timescale 1ns/1ps
module ptw_walker #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned DIR_IDX_W = 10,
    parameter int unsigned TBL_IDX_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_en,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic              rsp_fault,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [ADDR_W-1:0] mem_rdata
);
    import ptw_pkg::*;

    localparam int unsigned OFF_W   = ADDR_W - DIR_IDX_W - TBL_IDX_W;
    localparam int unsigned FRAME_W = ADDR_W - OFF_W;
    localparam int unsigned DIR_LSB = OFF_W + TBL_IDX_W;
    localparam int unsigned SHIFT   = $clog2(ENTRY_BYTES);

    typedef struct packed {
        walk_state_e       state;
        logic [ADDR_W-1:0] vaddr;
        logic [ADDR_W-1:0] base;
        logic [ADDR_W-1:0] tbl_base;
        logic [ADDR_W-1:0] paddr;
        logic              fault;
    } walk_regs_t;

    walk_regs_t walk_d, walk_q;

    logic [DIR_IDX_W-1:0] dir_idx;
    logic [TBL_IDX_W-1:0] tbl_idx;
    logic [OFF_W-1:0]     page_off;
    logic [ADDR_W-1:0]    dir_entry_addr;
    logic [ADDR_W-1:0]    tbl_entry_addr;
    logic                 entry_present;
    logic [FRAME_W-1:0]   entry_frame;

    always_comb begin
        dir_idx  = walk_q.vaddr[ADDR_W-1 -: DIR_IDX_W];
        tbl_idx  = walk_q.vaddr[OFF_W +: TBL_IDX_W];
        page_off = walk_q.vaddr[OFF_W-1:0];
    end

    ptw_entry_addr #(
        .ADDR_W(ADDR_W), .IDX_W(DIR_IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) dir_addr_i (
        .base_i(walk_q.base), .idx_i(dir_idx), .addr_o(dir_entry_addr)
    );

    ptw_entry_addr #(
        .ADDR_W(ADDR_W), .IDX_W(TBL_IDX_W), .ENTRY_BYTES(ENTRY_BYTES)
    ) tbl_addr_i (
        .base_i(walk_q.tbl_base), .idx_i(tbl_idx), .addr_o(tbl_entry_addr)
    );

    ptw_entry_decode #(
        .ENTRY_W(ADDR_W), .FRAME_W(FRAME_W), .PRESENT_BIT(0)
    ) decode_i (
        .entry_i(mem_rdata), .present_o(entry_present), .frame_o(entry_frame)
    );

    // Next-state computation
    always_comb begin
        walk_d = walk_q;
        unique case (walk_q.state)
            WALK_IDLE: begin
                if (req_valid) begin
                    walk_d.vaddr = req_vaddr;
                    walk_d.base  = dir_base;
                    walk_d.fault = 1'b0;
                    if (paging_en) begin
                        walk_d.state = WALK_DIR;
                    end else begin
                        walk_d.paddr = req_vaddr;
                        walk_d.state = WALK_RESP;
                    end
                end
            end
            WALK_DIR: begin
                if (mem_rvalid) begin
                    if (entry_present) begin
                        walk_d.tbl_base = {entry_frame, {OFF_W{1'b0}}};
                        walk_d.state    = WALK_TBL;
                    end else begin
                        walk_d.fault = 1'b1;
                        walk_d.paddr = '0;
                        walk_d.state = WALK_RESP;
                    end
                end
            end
            WALK_TBL: begin
                if (mem_rvalid) begin
                    if (entry_present) begin
                        walk_d.paddr = {entry_frame, page_off};
                    end else begin
                        walk_d.fault = 1'b1;
                        walk_d.paddr = '0;
                    end
                    walk_d.state = WALK_RESP;
                end
            end
            WALK_RESP: begin
                walk_d.state = WALK_IDLE;
            end
            default: walk_d.state = WALK_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            walk_q <= '{state: WALK_IDLE, default: '0};
        end else begin
            walk_q <= walk_d;
        end
    end

    always_comb begin
        req_ready = (walk_q.state == WALK_IDLE);
        mem_req   = (walk_q.state == WALK_DIR) || (walk_q.state == WALK_TBL);
        mem_addr  = (walk_q.state == WALK_TBL) ? tbl_entry_addr : dir_entry_addr;
        rsp_valid = (walk_q.state == WALK_RESP);
        rsp_paddr = walk_q.paddr;
        rsp_fault = walk_q.fault;
    end

    // Assertions
    p_bypass_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en) |=>
            (rsp_valid && !rsp_fault && !mem_req && rsp_paddr == $past(req_vaddr)))
        else $error("R2 bypass response wrong");

    p_dir_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && paging_en) |=>
            (mem_req && mem_addr == $past(dir_base) +
                (ADDR_W'($past(req_vaddr[ADDR_W-1:DIR_LSB])) << SHIFT)))
        else $error("R3 directory read address wrong");

    // R6 and R7: every fault response carries a zero address
    p_fault_no_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0))
        else $error("R6/R7 fault with nonzero address");

    p_busy_not_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready)
        else $error("R8 ready during read");

    p_hold_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)))
        else $error("R9 read dropped or address moved");

    p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready))
        else $error("R10 response not a single pulse");

endmodule

// File: tb/ptw_walker_tb_top.sv
`timescale 1ns/1ps
module ptw_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic [31:0] dir_base = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int n_checks = 0;
    int n_fails  = 0;
    int lat      = 0;
    int rd_cnt   = 0;
    logic [31:0] rd_log [0:3];
    logic [31:0] mem [logic [31:0]];

    localparam logic [31:0] DIR_A = 32'h0001_0000;

    always #2.5 clk = ~clk;

    ptw_walker dut_i (
        .clk(clk), .rst_n(rst_n), .paging_en(paging_en), .dir_base(dir_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    // Memory responder: waits lat idle cycles then returns one beat
    initial begin
        int wait_cnt = 0;
        forever begin
            @(negedge clk);
            if (mem_rvalid) begin
                mem_rvalid = 1'b0;
                wait_cnt = 0;
            end else if (mem_req) begin
                if (wait_cnt >= lat) begin
                    mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
                    if (rd_cnt < 4) rd_log[rd_cnt] = mem_addr;
                    rd_cnt++;
                    mem_rvalid = 1'b1;
                    wait_cnt = 0;
                end else begin
                    wait_cnt++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Issue one request and wait for its response; returns cycles to response
    task automatic walk(input logic [31:0] va, input bit hold_other,
                        output logic [31:0] pa, output logic flt, output int cyc);
        rd_cnt = 0;
        cyc = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_vaddr = va;
        @(negedge clk);
        if (hold_other) req_vaddr = va ^ 32'hFFC0_0000;
        else req_valid = 1'b0;
        cyc = 1;
        while (!rsp_valid && cyc < 500) begin
            if (hold_other) chk(req_ready == 1'b0, "R8 ready low in walk", 32'(req_ready), 32'h0);
            @(negedge clk);
            cyc++;
        end
        pa  = rsp_paddr;
        flt = rsp_fault;
        req_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R10 single-cycle response", 32'(rsp_valid), 32'h0);
        chk(req_ready == 1'b1, "R10 ready after response", 32'(req_ready), 32'h1);
    endtask

    task automatic t_reset();
        chk(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 32'h1);
        chk(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 32'h0);
        chk(mem_req == 1'b0, "R1 reset mem_req", 32'(mem_req), 32'h0);
    endtask

    task automatic t_bypass();
        logic [31:0] pa; logic f; int c;
        paging_en = 1'b0;
        walk(32'hDEAD_BEEF, 1'b0, pa, f, c);
        chk(pa == 32'hDEAD_BEEF, "R2 bypass address", pa, 32'hDEAD_BEEF);
        chk(f == 1'b0, "R2 bypass no fault", 32'(f), 32'h0);
        chk(c == 1, "R2 bypass latency", 32'(c), 32'h1);
        chk(rd_cnt == 0, "R2 bypass no reads", 32'(rd_cnt), 32'h0);
    endtask

    task automatic t_basic();
        logic [31:0] pa; logic f; int c;
        paging_en = 1'b1;
        lat = 0;
        walk({10'd3, 10'd5, 12'h123}, 1'b0, pa, f, c);
        chk(rd_cnt == 2, "R5 two reads", 32'(rd_cnt), 32'h2);
        chk(rd_log[0] == DIR_A + 32'd12, "R3 directory address", rd_log[0], DIR_A + 32'd12);
        chk(rd_log[1] == 32'h0002_0014, "R4 table address", rd_log[1], 32'h0002_0014);
        chk(pa == 32'hABCD_E123, "R5 physical address", pa, 32'hABCD_E123);
        chk(f == 1'b0, "R5 no fault", 32'(f), 32'h0);
    endtask

    task automatic t_slow_edge();
        logic [31:0] pa; logic f; int c;
        lat = 5;
        walk(32'hFFFF_FFFF, 1'b0, pa, f, c);
        chk(rd_log[0] == DIR_A + 32'h0FFC, "R3 top directory index", rd_log[0], DIR_A + 32'h0FFC);
        chk(rd_log[1] == 32'h0003_0FFC, "R4 entry low bits ignored", rd_log[1], 32'h0003_0FFC);
        chk(pa == 32'h1234_5FFF, "R9 slow memory result", pa, 32'h1234_5FFF);
        chk(rd_cnt == 2, "R9 one read per level", 32'(rd_cnt), 32'h2);
        chk(c >= 12, "R9 waited for data", 32'(c), 32'd12);
        lat = 0;
    endtask

    task automatic t_dir_fault();
        logic [31:0] pa; logic f; int c;
        walk({10'd7, 10'd1, 12'hABC}, 1'b0, pa, f, c);
        chk(f == 1'b1, "R6 directory fault flag", 32'(f), 32'h1);
        chk(pa == 32'h0, "R6 fault address zero", pa, 32'h0);
        chk(rd_cnt == 1, "R6 single read", 32'(rd_cnt), 32'h1);
    endtask

    task automatic t_tbl_fault();
        logic [31:0] pa; logic f; int c;
        walk({10'd3, 10'd6, 12'h456}, 1'b0, pa, f, c);
        chk(f == 1'b1, "R7 table fault flag", 32'(f), 32'h1);
        chk(pa == 32'h0, "R7 fault address zero", pa, 32'h0);
        chk(rd_cnt == 2, "R7 two reads", 32'(rd_cnt), 32'h2);
    endtask

    task automatic t_busy_hold();
        logic [31:0] pa; logic f; int c; int extra;
        lat = 4;
        walk({10'd3, 10'd5, 12'h777}, 1'b1, pa, f, c);
        chk(pa == 32'hABCD_E777, "R8 first request result", pa, 32'hABCD_E777);
        extra = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (rsp_valid || mem_req) extra++;
        end
        chk(extra == 0, "R8 held request ignored", 32'(extra), 32'h0);
        chk(rd_cnt == 2, "R8 no extra reads", 32'(rd_cnt), 32'h2);
        lat = 0;
    endtask

    task automatic t_midwalk_change();
        logic [31:0] pa; logic f; int c;
        lat = 3;
        fork
            walk({10'd3, 10'd5, 12'h0AA}, 1'b0, pa, f, c);
            begin
                @(negedge clk); @(negedge clk);
                paging_en = 1'b0;
                dir_base  = 32'h0;
            end
        join
        chk(pa == 32'hABCD_E0AA, "R11 controls sampled at accept", pa, 32'hABCD_E0AA);
        chk(rd_log[0] == DIR_A + 32'd12, "R11 directory base held", rd_log[0], DIR_A + 32'd12);
        paging_en = 1'b1;
        dir_base  = DIR_A;
        lat = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        mem[DIR_A + 32'd12]     = 32'h0002_0001;
        mem[32'h0002_0014]      = 32'hABCD_E001;
        mem[32'h0002_0018]      = 32'h5555_5000;
        mem[DIR_A + 32'h0FFC]   = 32'h0003_0FFF;
        mem[32'h0003_0FFC]      = 32'h1234_5F0F;
        mem[DIR_A + 32'd28]     = 32'h0004_0000;
        dir_base = DIR_A;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bypass();
        t_basic();
        t_slow_edge();
        t_dir_fault();
        t_tbl_fault();
        t_busy_hold();
        t_midwalk_change();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule